// File: doc/BRIEF.md
# Processor Exception State Controller

This block tracks the execution state of a small processor core and steers it into its exception handlers. It watches several event sources: a three-bit active-low interrupt priority input, instruction-stage flags for a trap instruction (with its trap number) and a zero-divisor divide, and bus error and misaligned access flags from the memory side. From these it picks one source, rewrites the mode and mask fields of the 16-bit status register, and asks for the handler pointer. The request is a strobe plus a byte address that lies inside a fixed 1 KiB table starting at address zero. The address is the vector number times four.

There are four named states. NORMAL (code 0) means instructions are executing. STOPPED (code 1) is entered by a stop request, which also loads a new status value. EXCEPTION (code 2) means the handler pointer fetch is in progress. HALTED (code 3) is the double-fault lock. The named transitions are:
- reset-entry: reset leads to EXCEPTION with vector 0.
- take: NORMAL goes to EXCEPTION on any selected source.
- stop: NORMAL goes to STOPPED.
- wake: STOPPED goes to EXCEPTION on an accepted interrupt.
- resume: EXCEPTION goes to NORMAL on fetch acknowledge.
- double-fault: EXCEPTION goes to HALTED on a bus or address error.

HALTED is left only through reset. The stacking of the return context, instruction decode and the memory system sit outside this block. The only contact with them is the fetch strobe and its acknowledge.

Top module: `exc_state_ctrl`

## Requirements
- R1: While `rst_n` is low, and afterwards until an acknowledge, the state is EXCEPTION (2), the status register reads 0x2700, the vector address is 0x000 and the fetch strobe is high.
- R2: In EXCEPTION, `fetch_ack` with no bus or address error moves the state to NORMAL (0) at the next clock edge.
- R3: In NORMAL, a bus error enters EXCEPTION with vector 2 (address 0x008). An address error alone uses vector 3 (0x00C). Bus error wins over address error, and either one wins over trap, divide and interrupt.
- R4: In NORMAL, a trap with number n (4 bits) enters EXCEPTION with vector 32+n (address 4*(32+n)). A zero-divide uses vector 5 (0x014). A trap wins over a zero-divide, and both win over interrupts.
- R5: The interrupt level is the bitwise inverse of `ipl_n`. In NORMAL or STOPPED, a level greater than the mask (status bits 10:8) is accepted. It uses vector 24+level, and the mask is set to that level.
- R6: Level 7 is accepted once when it arrives, even with mask 7. Holding it at 7 does not cause a second acceptance.
- R7: Every exception entry clears T (status bit 15) and sets S (bit 13). The other bits are kept, except the mask on interrupts.
- R8: In NORMAL with no exception source, `stop_req` moves the state to STOPPED (1) and loads `stop_sr` into the status register.
- R9: In STOPPED, trap, zero-divide, bus error, address error and stop requests have no effect. Only an accepted interrupt leaves the state.
- R10: A bus or address error in EXCEPTION moves the state to HALTED (3). HALTED ignores every input until reset.
- R11: `vec_stb` is high exactly in EXCEPTION. `vec_addr` is the vector number shifted left by two, and a rising strobe always sees S set and T clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ipl_n | input | 3 | Active-low interrupt priority level |
| stop_req | input | 1 | Stop instruction executed |
| stop_sr | input | 16 | Status value loaded by the stop |
| trap_req | input | 1 | Trap instruction executed |
| trap_num | input | 4 | Trap number |
| div0_req | input | 1 | Divide with zero divisor |
| bus_err | input | 1 | Access to a nonexistent location |
| addr_err | input | 1 | Word access at an odd address |
| fetch_ack | input | 1 | Handler pointer fetch completed |
| state | output | 2 | Current state code |
| vec_addr | output | 10 | Vector table byte address |
| vec_stb | output | 1 | Vector fetch request |
| sr | output | 16 | Status register |

## Verification
The source selector is driven three ways.
- Single sources alone confirm each vector number.
- Coincident groups (trap with zero-divide and an interrupt, bus with address error and a trap, zero-divide with an interrupt) tell apart each rung of the priority order.
- Interrupt levels below, equal to and above the mask separate the strict comparison from an inclusive one.

A held level 7 under mask 7 distinguishes edge acceptance from level acceptance. Stimulus applied in STOPPED and in HALTED, with the state and status read back afterwards, shows which inputs those states ignore.

// File: rtl/exc_pkg.sv
package exc_pkg;
    typedef enum logic [1:0] {
        ST_NORM = 2'd0,
        ST_STOP = 2'd1,
        ST_EXC  = 2'd2,
        ST_HALT = 2'd3
    } exc_state_t;

    localparam int SR_W         = 16;
    localparam int SR_T_BIT     = 15;
    localparam int SR_S_BIT     = 13;
    localparam int SR_MASK_LO   = 8;
    localparam int LVL_W        = 3;
    localparam int VEC_W        = 8;
    localparam int VN_RESET     = 0;
    localparam int VN_BUS       = 2;
    localparam int VN_ADDR      = 3;
    localparam int VN_DIV0      = 5;
    localparam int VN_AUTO_BASE = 24;
    localparam int VN_TRAP_BASE = 32;
    localparam logic [SR_W-1:0] SR_RESET = 16'h2700;
endpackage

// File: rtl/exc_irq_gate.sv
module exc_irq_gate
    import exc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] ipl_n,
    input  logic [LVL_W-1:0] mask,
    input  logic             take_en,
    output logic [LVL_W-1:0] level,
    output logic             take
);
    localparam logic [LVL_W-1:0] LVL_TOP = '1;

    logic [LVL_W-1:0] level_prev;
    logic             top_pend;
    logic             top_edge;
    logic             top_armed;

    assign level     = ~ipl_n;
    assign top_edge  = (level == LVL_TOP) && (level_prev != LVL_TOP);
    assign top_armed = (level == LVL_TOP) && (top_pend || top_edge);
    assign take      = take_en && ((level > mask) || top_armed);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_prev <= '0;
            top_pend   <= 1'b0;
        end else begin
            level_prev <= level;
            if (take && (level == LVL_TOP))
                top_pend <= 1'b0;
            else if (top_edge)
                top_pend <= 1'b1;
        end
    end

    // R6: a held top level is taken only once.
    p_top_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && level == LVL_TOP && mask == LVL_TOP) |=>
            !(take && level == LVL_TOP && $past(level) == LVL_TOP && mask == LVL_TOP && !top_pend));
endmodule

// File: rtl/exc_src_sel.sv
module exc_src_sel
    import exc_pkg::*;
#(
    parameter int TRAP_W = 4
) (
    input  logic              src_en,
    input  logic              bus_err,
    input  logic              addr_err,
    input  logic              trap_req,
    input  logic [TRAP_W-1:0] trap_num,
    input  logic              div0_req,
    input  logic              irq_take,
    input  logic [LVL_W-1:0]  irq_level,
    output logic              hit,
    output logic              is_irq,
    output logic [VEC_W-1:0]  vec_num
);
    always_comb begin
        hit     = 1'b1;
        is_irq  = 1'b0;
        vec_num = VEC_W'(VN_RESET);
        if (src_en && bus_err)
            vec_num = VEC_W'(VN_BUS);
        else if (src_en && addr_err)
            vec_num = VEC_W'(VN_ADDR);
        else if (src_en && trap_req)
            vec_num = VEC_W'(VN_TRAP_BASE) + VEC_W'(trap_num);
        else if (src_en && div0_req)
            vec_num = VEC_W'(VN_DIV0);
        else if (irq_take) begin
            is_irq  = 1'b1;
            vec_num = VEC_W'(VN_AUTO_BASE) + VEC_W'(irq_level);
        end else
            hit = 1'b0;
    end

    // R3: no instruction source is ever picked while a bus error is present.
    always_comb begin
        if (src_en && bus_err)
            a_bus_first_r3: assert (vec_num == VEC_W'(VN_BUS) && !is_irq);
    end
endmodule

// File: rtl/exc_state_ctrl.sv
module exc_state_ctrl
    import exc_pkg::*;
#(
    parameter int TRAP_W = 4,
    localparam int ADDR_W = VEC_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        ipl_n,
    input  logic              stop_req,
    input  logic [15:0]       stop_sr,
    input  logic              trap_req,
    input  logic [TRAP_W-1:0] trap_num,
    input  logic              div0_req,
    input  logic              bus_err,
    input  logic              addr_err,
    input  logic              fetch_ack,
    output logic [1:0]        state,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              vec_stb,
    output logic [15:0]       sr
);
    exc_state_t         st_q, st_d;
    logic [SR_W-1:0]    sr_q, sr_d;
    logic [VEC_W-1:0]   vn_q, vn_d;
    logic [LVL_W-1:0]   irq_level;
    logic               irq_take, sel_hit, sel_irq;
    logic [VEC_W-1:0]   sel_vec;
    logic               in_norm, in_stop, fault;

    assign in_norm = (st_q == ST_NORM);
    assign in_stop = (st_q == ST_STOP);
    assign fault   = bus_err || addr_err;

    exc_irq_gate u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ipl_n   (ipl_n),
        .mask    (sr_q[SR_MASK_LO +: LVL_W]),
        .take_en (in_norm || in_stop),
        .level   (irq_level),
        .take    (irq_take)
    );

    exc_src_sel #(.TRAP_W(TRAP_W)) u_sel (
        .src_en    (in_norm),
        .bus_err   (bus_err),
        .addr_err  (addr_err),
        .trap_req  (trap_req),
        .trap_num  (trap_num),
        .div0_req  (div0_req),
        .irq_take  (irq_take),
        .irq_level (irq_level),
        .hit       (sel_hit),
        .is_irq    (sel_irq),
        .vec_num   (sel_vec)
    );

    // next-state and next-status
    always_comb begin
        st_d = st_q;
        sr_d = sr_q;
        vn_d = vn_q;
        unique case (st_q)
            ST_NORM, ST_STOP: begin
                if (sel_hit) begin
                    st_d           = ST_EXC;
                    vn_d           = sel_vec;
                    sr_d[SR_T_BIT] = 1'b0;
                    sr_d[SR_S_BIT] = 1'b1;
                    if (sel_irq)
                        sr_d[SR_MASK_LO +: LVL_W] = irq_level;
                end else if (in_norm && stop_req) begin
                    st_d = ST_STOP;
                    sr_d = stop_sr;
                end
            end
            ST_EXC: begin
                if (fault)
                    st_d = ST_HALT;
                else if (fetch_ack)
                    st_d = ST_NORM;
            end
            ST_HALT: st_d = ST_HALT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_EXC;
            sr_q <= SR_RESET;
            vn_q <= VEC_W'(VN_RESET);
        end else begin
            st_q <= st_d;
            sr_q <= sr_d;
            vn_q <= vn_d;
        end
    end

    // outputs
    always_comb begin
        state    = st_q;
        sr       = sr_q;
        vec_stb  = (st_q == ST_EXC);
        vec_addr = {vn_q, 2'b00};
    end

    p_resume_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EXC && fetch_ack && !fault) |=> state == 2'd0);

    p_entry_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_stb) |-> (sr[SR_S_BIT] && !sr[SR_T_BIT]));

    p_wake_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stop && irq_take) |=> (vec_stb && sr[SR_MASK_LO +: LVL_W] == $past(irq_level)));

    p_stop_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_norm && stop_req && !fault && !trap_req && !div0_req && !irq_take)
            |=> (state == 2'd1 && sr == $past(stop_sr)));

    p_stop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stop && !irq_take) |=> (state == 2'd1 && $stable(sr)));

    p_double_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EXC && fault) |=> state == 2'd3);

    p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HALT) |=> (state == 2'd3 && !vec_stb && $stable(sr)));
endmodule

// File: tb/sim_exc_state_ctrl.sv
module sim_exc_state_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  ipl_n = 3'b111;
    logic        stop_req = 1'b0;
    logic [15:0] stop_sr = '0;
    logic        trap_req = 1'b0;
    logic [3:0]  trap_num = '0;
    logic        div0_req = 1'b0;
    logic        bus_err = 1'b0;
    logic        addr_err = 1'b0;
    logic        fetch_ack = 1'b0;
    logic [1:0]  state;
    logic [9:0]  vec_addr;
    logic        vec_stb;
    logic [15:0] sr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [1:0]  st;
        logic [15:0] sr;
        logic [9:0]  addr;
        logic        stb;
        string       tag;
    } item_t;
    item_t exp_q[$];

    always #5 clk = ~clk;

    exc_state_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ipl_n(ipl_n), .stop_req(stop_req),
        .stop_sr(stop_sr), .trap_req(trap_req), .trap_num(trap_num),
        .div0_req(div0_req), .bus_err(bus_err), .addr_err(addr_err),
        .fetch_ack(fetch_ack), .state(state), .vec_addr(vec_addr),
        .vec_stb(vec_stb), .sr(sr)
    );

    task automatic compare(input item_t e);
        checks++;
        if (state !== e.st || sr !== e.sr || vec_stb !== e.stb ||
            (e.stb && vec_addr !== e.addr)) begin
            errors++;
            $display("FAIL %s: got st=%0d sr=%h stb=%b addr=%h, want st=%0d sr=%h stb=%b addr=%h",
                     e.tag, state, sr, vec_stb, vec_addr, e.st, e.sr, e.stb, e.addr);
        end
    endtask

    // monitor: pops one expectation per clock edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) compare(exp_q.pop_front());
    end

    task automatic idle();
        @(negedge clk);
        ipl_n = 3'b111; stop_req = 0; trap_req = 0; trap_num = 0;
        div0_req = 0; bus_err = 0; addr_err = 0; fetch_ack = 0;
    endtask

    task automatic expect_next(input logic [1:0] st, input logic [15:0] s,
                               input logic [9:0] a, input logic b, input string tag);
        item_t it;
        it.st = st; it.sr = s; it.addr = a; it.stb = b; it.tag = tag;
        exp_q.push_back(it);
        @(posedge clk);
    endtask

    function automatic logic [2:0] lvl(input int l);
        return ~3'(l);
    endfunction

    task automatic check_reset(input string tag);
        item_t it;
        it.st = 2; it.sr = 16'h2700; it.addr = 10'h000; it.stb = 1; it.tag = tag;
        compare(it);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_reset("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_reset("R1 after release");

        idle(); fetch_ack = 1;                expect_next(0, 16'h2700, 0, 0, "R2 resume");
        idle(); ipl_n = lvl(5);               expect_next(0, 16'h2700, 0, 0, "R5 masked level 5");
        idle(); stop_req = 1; stop_sr = 16'h2300;
                                              expect_next(1, 16'h2300, 0, 0, "R8 stop load");
        idle(); trap_req = 1; div0_req = 1; bus_err = 1; addr_err = 1;
                stop_req = 1; stop_sr = 16'h0000;
                                              expect_next(1, 16'h2300, 0, 0, "R9 stopped ignores");
        idle(); ipl_n = lvl(3);               expect_next(1, 16'h2300, 0, 0, "R5 equal level ignored");
        idle(); ipl_n = lvl(4);               expect_next(2, 16'h2400, 10'h070, 1, "R5 wake level 4");
        idle(); fetch_ack = 1;                expect_next(0, 16'h2400, 0, 0, "R2 resume");
        idle(); trap_req = 1; trap_num = 5; div0_req = 1; ipl_n = lvl(6);
                                              expect_next(2, 16'h2400, 10'h094, 1, "R4 trap 5 wins");
        idle(); fetch_ack = 1;                expect_next(0, 16'h2400, 0, 0, "R2 resume");
        idle(); div0_req = 1; ipl_n = lvl(6); expect_next(2, 16'h2400, 10'h014, 1, "R4 div0 over irq");
        idle(); fetch_ack = 1;                expect_next(0, 16'h2400, 0, 0, "R2 resume");
        idle(); ipl_n = lvl(6);               expect_next(2, 16'h2600, 10'h078, 1, "R5 level 6");
        idle(); fetch_ack = 1;                expect_next(0, 16'h2600, 0, 0, "R2 resume");
        idle(); bus_err = 1; addr_err = 1; trap_req = 1;
                                              expect_next(2, 16'h2600, 10'h008, 1, "R3 bus first");
        idle(); fetch_ack = 1;                expect_next(0, 16'h2600, 0, 0, "R2 resume");
        idle(); addr_err = 1; div0_req = 1;   expect_next(2, 16'h2600, 10'h00C, 1, "R3 address error");
        idle(); fetch_ack = 1;                expect_next(0, 16'h2600, 0, 0, "R2 resume");
        idle(); stop_req = 1; stop_sr = 16'h8715;
                                              expect_next(1, 16'h8715, 0, 0, "R8 stop with T");
        idle(); ipl_n = lvl(7);               expect_next(2, 16'h2715, 10'h07C, 1, "R6 R7 level 7 arrives");
        idle(); ipl_n = lvl(7); fetch_ack = 1;
                                              expect_next(0, 16'h2715, 0, 0, "R2 resume");
        idle(); ipl_n = lvl(7);               expect_next(0, 16'h2715, 0, 0, "R6 held level 7 once");
        idle(); ipl_n = lvl(7);               expect_next(0, 16'h2715, 0, 0, "R6 still held");
        idle(); trap_req = 1; trap_num = 0;   expect_next(2, 16'h2715, 10'h080, 1, "R4 R11 trap 0");
        idle(); bus_err = 1; fetch_ack = 1;   expect_next(3, 16'h2715, 0, 0, "R10 double fault");
        idle(); fetch_ack = 1; trap_req = 1; ipl_n = lvl(7); stop_req = 1;
                                              expect_next(3, 16'h2715, 0, 0, "R10 halt ignores");
        idle(); addr_err = 1; ipl_n = lvl(2); expect_next(3, 16'h2715, 0, 0, "R10 halt stays");
        idle(); rst_n = 1'b0;
        @(negedge clk);
        check_reset("R1 reset from halt");
        rst_n = 1'b1;
        idle(); fetch_ack = 1;                expect_next(0, 16'h2700, 0, 0, "R2 resume after reset");
        idle();
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, want completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule